// File: doc/BRIEF.md
# Serial Stream Receiver with Request Pacing

This block takes a compressed audio elementary stream from an external source over three wires: a serial data line, a bit clock and a qualifier that marks which bit-clock edges carry data. The three wires are brought into the system clock domain through synchronizer flops, and the chosen bit-clock edge is detected there. Each qualified bit is shifted into a byte, most significant bit first. When the eighth bit arrives, the finished byte is written into a small receive FIFO. A byte-wide port with a valid/ready handshake drains the FIFO toward the decoder.

The block paces the source through a request line. The request is active while the FIFO has enough room. It drops when free space falls to a low-water mark and comes back only when free space has climbed to a higher mark. This hysteresis keeps the line from toggling on every byte. Configuration inputs select the sampling edge of the bit clock and the active level of the request line. A separate input switches request generation off, which holds the line permanently active so the source is never paused.

Top module: `serial_stream_rx`

## Requirements
- R1: While `rst` is high, `rdValid` is 0 and `reqOut` sits at its inactive level, which equals `cfgReqActiveLow`.
- R2: With `cfgClkFallEdge`=0, data is captured on rising edges of `serClk`. The first captured bit becomes bit 7 of the byte, and the byte is queued after the eighth captured bit.
- R3: With `cfgClkFallEdge`=1, data is captured on falling edges of `serClk` instead, and rising edges capture nothing.
- R4: While `serEnable` is low, `serClk` edges capture no bit and queue no byte.
- R5: Bits already captured before `serEnable` goes low are kept, and the byte is completed by the bits captured after it returns high.
- R6: When the FIFO (64 bytes by default) has 8 or fewer free entries, the request goes inactive. With 9 to 15 free entries it keeps its previous state.
- R7: The request becomes active again only once at least 16 entries are free.
- R8: `cfgReqActiveLow`=1 inverts the line, so that 0 means "send" and 1 means "stop".
- R9: With `cfgReqEnable`=0, `reqOut` is held at its active level whatever the fill level.
- R10: A byte completed while the FIFO is full and no read happens in that cycle is discarded. Bytes already stored are unchanged.
- R11: `rdValid` is high exactly while the FIFO holds data. Bytes leave in arrival order, one per cycle in which `rdValid` and `rdReady` are both high, and `rdData` holds steady while `rdValid` is high and `rdReady` is low.
- R12: A synchronous reset empties the FIFO and discards a partly assembled byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock. Each `serClk` phase must last at least 3 cycles of it. |
| rst | input | 1 | Synchronous reset, active high |
| serClk | input | 1 | Serial bit clock from the source |
| serData | input | 1 | Serial data, MSB of each byte first |
| serEnable | input | 1 | Bit qualifier; edges are ignored while it is low |
| cfgClkFallEdge | input | 1 | 0: sample on rising edge, 1: sample on falling edge |
| cfgReqActiveLow | input | 1 | 0: request active high, 1: request active low |
| cfgReqEnable | input | 1 | 1: request follows the fill level, 0: request held active |
| reqOut | output | 1 | Data request toward the source |
| rdData | output | 8 | Oldest byte in the FIFO |
| rdValid | output | 1 | FIFO holds at least one byte |
| rdReady | input | 1 | Consumer accepts `rdData` in this cycle |

## Verification
The serial capture path can write a byte into the FIFO in the same cycle in which the read port removes one. The count, the pointers and the request hysteresis must all handle that overlap. The bench provokes it by streaming bytes while `rdReady` follows a pseudo-random pattern that changes every cycle, so completed bytes land on cycles with and without a read. A scoreboard queue judges the result: any lost, duplicated or reordered byte shows up as a mismatch or as a leftover entry. Near the full point, the request transitions are checked at fixed fill levels.

// File: rtl/srx_pkg.sv
package srx_pkg;
  // Strobes sent from the control half to the datapath half each cycle
  typedef struct packed {
    logic capture;  // take one serial bit
    logic bitVal;   // the value of that bit
    logic push;     // this bit completes a byte
  } rxStrobe_t;
endpackage

// File: rtl/srx_ctrl.sv
module srx_ctrl
  import srx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int FREE_W      = 7,
  parameter int SYNC_STAGES = 2,
  parameter int LOW_MARK    = 8,
  parameter int HIGH_MARK   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              serClk,
  input  logic              serData,
  input  logic              serEnable,
  input  logic              cfgClkFallEdge,
  input  logic [FREE_W-1:0] freeCount,
  output rxStrobe_t         strobe,
  output logic              reqState
);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);
  localparam logic [FREE_W-1:0] LOW_LIM  = FREE_W'(LOW_MARK);
  localparam logic [FREE_W-1:0] HIGH_LIM = FREE_W'(HIGH_MARK);

  logic [SYNC_STAGES-1:0] clkSync, dataSync, enSync;
  logic                   clkPrev;
  logic [BIT_W-1:0]       bitCnt;

  // Bring the serial wires into the system clock domain
  always_ff @(posedge clk) begin
    if (rst) begin
      clkSync  <= '0;
      dataSync <= '0;
      enSync   <= '0;
      clkPrev  <= 1'b0;
    end else begin
      clkSync  <= {clkSync[SYNC_STAGES-2:0], serClk};
      dataSync <= {dataSync[SYNC_STAGES-2:0], serData};
      enSync   <= {enSync[SYNC_STAGES-2:0], serEnable};
      clkPrev  <= clkSync[SYNC_STAGES-1];
    end
  end

  logic clkNow, roseEdge, fellEdge, sampleEdge, takeBit;
  assign clkNow     = clkSync[SYNC_STAGES-1];
  assign roseEdge   = clkNow & ~clkPrev;
  assign fellEdge   = ~clkNow & clkPrev;
  assign sampleEdge = cfgClkFallEdge ? fellEdge : roseEdge;
  assign takeBit    = sampleEdge & enSync[SYNC_STAGES-1];

  // Bit position inside the byte; kept while the qualifier is low
  always_ff @(posedge clk) begin
    if (rst) begin
      bitCnt <= '0;
    end else if (takeBit) begin
      bitCnt <= (bitCnt == LAST_BIT) ? '0 : bitCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.capture = takeBit;
    strobe.bitVal  = dataSync[SYNC_STAGES-1];
    strobe.push    = takeBit && (bitCnt == LAST_BIT);
  end

  // Request with hysteresis between the two free-space marks
  always_ff @(posedge clk) begin
    if (rst) begin
      reqState <= 1'b0;
    end else if (freeCount <= LOW_LIM) begin
      reqState <= 1'b0;
    end else if (freeCount >= HIGH_LIM) begin
      reqState <= 1'b1;
    end
  end
endmodule

// File: rtl/srx_datapath.sv
module srx_datapath
  import srx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  parameter int FREE_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  rxStrobe_t         strobe,
  input  logic              rdReady,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic [FREE_W-1:0] freeCount
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam logic [FREE_W-1:0] FULL_CNT = FREE_W'(DEPTH);

  logic [DATA_W-2:0]  shiftReg;
  logic [DATA_W-1:0]  assembled;
  logic [DATA_W-1:0]  mem [DEPTH];
  logic [ADDR_W-1:0]  wrPtr, rdPtr;
  logic [FREE_W-1:0]  count;
  logic               full, pop, accept;

  assign assembled = {shiftReg, strobe.bitVal};
  assign full      = (count == FULL_CNT);
  assign rdValid   = (count != '0);
  assign pop       = rdValid & rdReady;
  assign accept    = strobe.push & (~full | pop);
  assign rdData    = mem[rdPtr];
  assign freeCount = FULL_CNT - count;

  // MSB-first shifter for the bits ahead of the last one
  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
    end else if (strobe.capture) begin
      shiftReg <= {shiftReg[DATA_W-3:0], strobe.bitVal};
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      mem[wrPtr] <= assembled;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (accept) wrPtr <= wrPtr + 1'b1;
      if (pop)    rdPtr <= rdPtr + 1'b1;
      case ({accept, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/serial_stream_rx.sv
module serial_stream_rx
  import srx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DEPTH       = 64,
  parameter int SYNC_STAGES = 2,
  parameter int LOW_MARK    = 8,
  parameter int HIGH_MARK   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              serClk,
  input  logic              serData,
  input  logic              serEnable,
  input  logic              cfgClkFallEdge,
  input  logic              cfgReqActiveLow,
  input  logic              cfgReqEnable,
  output logic              reqOut,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  input  logic              rdReady
);
  localparam int FREE_W = $clog2(DEPTH) + 1;

  rxStrobe_t         strobe;
  logic              reqState;
  logic [FREE_W-1:0] freeCount;
  logic              reqActive;

  srx_ctrl #(
    .DATA_W(DATA_W), .FREE_W(FREE_W), .SYNC_STAGES(SYNC_STAGES),
    .LOW_MARK(LOW_MARK), .HIGH_MARK(HIGH_MARK)
  ) u_ctrl (
    .clk(clk), .rst(rst), .serClk(serClk), .serData(serData),
    .serEnable(serEnable), .cfgClkFallEdge(cfgClkFallEdge),
    .freeCount(freeCount), .strobe(strobe), .reqState(reqState)
  );

  srx_datapath #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .FREE_W(FREE_W)
  ) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .rdReady(rdReady),
    .rdData(rdData), .rdValid(rdValid), .freeCount(freeCount)
  );

  assign reqActive = ~rst & (cfgReqEnable ? reqState : 1'b1);
  assign reqOut    = reqActive ^ cfgReqActiveLow;
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
  parameter int DATA_W    = 8,
  parameter int FREE_W    = 7,
  parameter int LOW_MARK  = 8,
  parameter int HIGH_MARK = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              rdValid,
  input logic              rdReady,
  input logic [DATA_W-1:0] rdData,
  input logic              reqOut,
  input logic              cfgReqActiveLow,
  input logic              cfgReqEnable,
  input logic [FREE_W-1:0] freeCount,
  input logic              reqState
);
  assert_reset_empty_R1: assert property (@(posedge clk) rst |=> !rdValid);

  assert_reset_req_idle_R1: assert property (@(posedge clk)
    rst |-> reqOut == cfgReqActiveLow);

  assert_hold_data_R11: assert property (@(posedge clk) disable iff (rst)
    rdValid && !rdReady |=> rdValid && $stable(rdData));

  assert_req_drop_R6: assert property (@(posedge clk) disable iff (rst)
    freeCount <= FREE_W'(LOW_MARK) |=> !reqState);

  assert_req_raise_R7: assert property (@(posedge clk) disable iff (rst)
    freeCount >= FREE_W'(HIGH_MARK) |=> reqState);

  assert_req_forced_R9: assert property (@(posedge clk) disable iff (rst)
    !cfgReqEnable |-> reqOut != cfgReqActiveLow);

  assert_full_stays_R10: assert property (@(posedge clk) disable iff (rst)
    freeCount == '0 && !rdReady |=> freeCount == '0);
endmodule

bind serial_stream_rx srx_checker #(
  .DATA_W(DATA_W), .FREE_W(FREE_W), .LOW_MARK(LOW_MARK), .HIGH_MARK(HIGH_MARK)
) u_chk (
  .clk(clk), .rst(rst), .rdValid(rdValid), .rdReady(rdReady), .rdData(rdData),
  .reqOut(reqOut), .cfgReqActiveLow(cfgReqActiveLow), .cfgReqEnable(cfgReqEnable),
  .freeCount(freeCount), .reqState(reqState)
);

// File: tb/serial_stream_rx_tb.sv
module serial_stream_rx_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic serClk = 1'b0, serData = 1'b0, serEnable = 1'b0;
  logic cfgClkFallEdge = 1'b0, cfgReqActiveLow = 1'b1, cfgReqEnable = 1'b1;
  logic reqOut, rdValid, rdReady;
  logic [7:0] rdData;
  logic autoReady = 1'b0, manualReady = 1'b0;
  logic [7:0] lfsr = 8'h5b;

  int checks = 0;
  int failures = 0;
  string curTag = "R11";
  logic [7:0] expQ[$];

  always #5 clk = ~clk;

  assign rdReady = autoReady ? lfsr[0] : manualReady;

  serial_stream_rx u_dut (
    .clk(clk), .rst(rst), .serClk(serClk), .serData(serData),
    .serEnable(serEnable), .cfgClkFallEdge(cfgClkFallEdge),
    .cfgReqActiveLow(cfgReqActiveLow), .cfgReqEnable(cfgReqEnable),
    .reqOut(reqOut), .rdData(rdData), .rdValid(rdValid), .rdReady(rdReady)
  );

  always @(posedge clk) begin
    #1 lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every read handshake (R11)
  always @(negedge clk) begin
    if (!rst && rdValid && rdReady) begin
      checks++;
      if (expQ.size() == 0) begin
        failures++;
        $display("FAIL %s unexpected byte actual=%0d expected=none", curTag, rdData);
      end else begin
        logic [7:0] e;
        e = expQ.pop_front();
        if (rdData !== e) begin
          failures++;
          $display("FAIL %s byte actual=%0d expected=%0d", curTag, rdData, e);
        end
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Serial bits, MSB first; the sampled edge leaves the idle level
  task automatic sendBits(input logic [7:0] v, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      serData = v[i];
      cyc(4);
      serClk = ~cfgClkFallEdge;
      cyc(4);
      serClk = cfgClkFallEdge;
    end
    cyc(4);
  endtask

  task automatic sendByte(input logic [7:0] v, input bit expect_it);
    if (expect_it) expQ.push_back(v);
    sendBits(v, 8);
  endtask

  task automatic popOne();
    manualReady = 1'b1;
    cyc(1);
    manualReady = 1'b0;
  endtask

  task automatic drain(input string tag);
    curTag = tag;
    manualReady = 1'b1;
    cyc(80);
    manualReady = 1'b0;
    cyc(2);
    check({tag, " drained rdValid"}, rdValid, 0);
    check({tag, " scoreboard empty"}, expQ.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R11 watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cyc(3);
    @(negedge clk);
    check("R1 reset rdValid", rdValid, 0);
    check("R1 reset reqOut inactive low-polarity", reqOut, 1);
    cyc(1);
    cfgReqActiveLow = 1'b0;
    cyc(1);
    check("R1 reset reqOut inactive high-polarity", reqOut, 0);
    rst = 1'b0;
    serEnable = 1'b1;
    cyc(4);
    check("R7 request active when empty", reqOut, 1);

    // R2: rising edge, MSB first
    curTag = "R2";
    sendByte(8'hA1, 1);
    sendByte(8'h3C, 1);
    cyc(2);
    check("R2 byte queued rdValid", rdValid, 1);
    check("R11 first byte on port", rdData, 8'hA1);
    drain("R2");

    // R3: falling edge sampling
    serEnable = 1'b0;
    cfgClkFallEdge = 1'b1;
    cyc(2);
    serClk = 1'b1;
    cyc(6);
    serEnable = 1'b1;
    curTag = "R3";
    sendByte(8'h96, 1);
    sendByte(8'h0F, 1);
    drain("R3");
    serEnable = 1'b0;
    cfgClkFallEdge = 1'b0;
    cyc(2);
    serClk = 1'b0;
    cyc(6);
    serEnable = 1'b1;

    // R4: qualifier low, nothing captured
    serEnable = 1'b0;
    sendByte(8'hFF, 0);
    sendByte(8'h55, 0);
    check("R4 ignored edges leave FIFO empty", rdValid, 0);
    serEnable = 1'b1;
    curTag = "R4";
    sendByte(8'hC3, 1);
    drain("R4");

    // R5: partial byte kept across qualifier-low gap
    curTag = "R5";
    expQ.push_back(8'hB7);
    sendBits(8'hB7, 4);
    serEnable = 1'b0;
    sendBits(8'h00, 3);
    check("R5 no byte yet", rdValid, 0);
    serEnable = 1'b1;
    sendBits(8'h70, 4);
    drain("R5");

    // R12: reset drops stored bytes and partial bits
    sendByte(8'h11, 0);
    sendByte(8'h22, 0);
    sendBits(8'hE0, 3);
    rst = 1'b1;
    cyc(3);
    rst = 1'b0;
    cyc(2);
    check("R12 FIFO cleared", rdValid, 0);
    curTag = "R12";
    sendByte(8'h5A, 1);
    drain("R12");

    // R6/R7 hysteresis, R8 polarity, R9 disable, R10 overflow
    curTag = "R10";
    for (int i = 0; i < 55; i++) sendByte(8'(i * 37 + 5), 1);
    cyc(6);
    check("R6 still active at 9 free", reqOut, 1);
    sendByte(8'(55 * 37 + 5), 1);
    cyc(6);
    check("R6 inactive at 8 free", reqOut, 0);
    for (int i = 0; i < 7; i++) popOne();
    cyc(4);
    check("R7 held inactive at 15 free", reqOut, 0);
    popOne();
    cyc(4);
    check("R7 active again at 16 free", reqOut, 1);
    cfgReqActiveLow = 1'b1;
    cyc(1);
    check("R8 inverted active level", reqOut, 0);
    cfgReqActiveLow = 1'b0;
    for (int i = 56; i < 64; i++) sendByte(8'(i * 37 + 5), 1);
    cyc(6);
    check("R6 inactive at 8 free again", reqOut, 0);
    cfgReqEnable = 1'b0;
    cyc(1);
    check("R9 forced active when disabled", reqOut, 1);
    cfgReqActiveLow = 1'b1;
    cyc(1);
    check("R9 forced active low polarity", reqOut, 0);
    cfgReqActiveLow = 1'b0;
    cfgReqEnable = 1'b1;
    for (int i = 64; i < 72; i++) sendByte(8'(i * 37 + 5), 1);
    cyc(4);
    check("R10 full request inactive", reqOut, 0);
    sendByte(8'hEE, 0);
    sendByte(8'hDD, 0);
    check("R10 oldest byte intact", rdData, 8'(8 * 37 + 5));
    drain("R10");

    // Concurrent write and read under random ready
    curTag = "R11";
    autoReady = 1'b1;
    for (int i = 0; i < 24; i++) sendByte(8'(i * 91 + 13), 1);
    cyc(200);
    autoReady = 1'b0;
    drain("R11");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule